// File: doc/BRIEF.md
# Accumulator Execute Unit

This block is the execute stage of a compact 8-bit accumulator machine. It holds a working register (W), an array of 128 byte-wide file registers, and three status flags: carry, digit carry (carry out of the low nibble) and zero. Each accepted operation reads its operands, computes a result and writes it back in one rising clock edge. Results go to W or to the addressed file register.

The unit performs six operations. It can add a literal to W, add a file register to W, AND a literal into W, AND a file register with W, clear one bit of a file register and set one bit of a file register. For the two file-register arithmetic operations, a destination input chooses where the result goes. Each operation updates only its own subset of flags.

The input side is a valid/ready stream of decoded operations. Ready is always high, so the unit never applies back-pressure. An operation is accepted on every rising edge where valid is high. W and the flags are visible on output ports. Any file register can be read combinationally through a separate debug address.

Top module: `acc_exec_unit`

## Requirements
- R1: A synchronous reset clears W, all three flags and every file register to zero.
- R2: Operation code 0 adds the literal to W (modulo 256) and writes the sum to W. Carry becomes the carry out of bit 7, digit carry becomes the carry out of bit 3, and zero is set exactly when the 8-bit sum is 0.
- R3: Operation code 1 adds the addressed file register to W and updates carry, digit carry and zero as in R2. With the destination at 0 the sum goes to W and the file register is unchanged. With the destination at 1 the sum goes to the file register and W is unchanged.
- R4: Operation code 2 ANDs the literal into W and sets zero from the result. Carry and digit carry keep their values.
- R5: Operation code 3 ANDs W with the addressed file register, routes the result by the destination bit as in R3, and updates only zero.
- R6: Operation code 4 clears bit `in_bit` of the addressed file register and leaves its other seven bits, W and all flags unchanged.
- R7: Operation code 5 sets bit `in_bit` of the addressed file register and leaves its other seven bits, W and all flags unchanged.
- R8: While `in_valid` is low, and for operation codes 6 and 7, no part of W, the flags or the file array changes.
- R9: The literal operations (codes 0 and 2) ignore the destination bit. They always write W and never touch the file array.
- R10: `in_ready` is always 1. An operation accepted at a rising edge shows its effect on the outputs immediately after that edge. `dbg_data` follows `dbg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the input stream |
| in_ready | output | 1 | Always 1; the unit accepts every cycle |
| in_op | input | 3 | Operation code (0 to 5 defined, 6 and 7 no-op) |
| in_addr | input | 7 | File register address |
| in_lit | input | 8 | Literal operand |
| in_bit | input | 3 | Bit index for bit clear and bit set |
| in_dest | input | 1 | Result destination for file operations: 0 = W, 1 = file |
| w_out | output | 8 | Current W register |
| flag_c | output | 1 | Carry flag |
| flag_dc | output | 1 | Digit carry flag |
| flag_z | output | 1 | Zero flag |
| dbg_addr | input | 7 | Debug read address into the file array |
| dbg_data | output | 8 | File register contents at `dbg_addr` |

## Verification
The assertions assume that the control inputs carry known values whenever reset is low. They also assume that `in_valid` is the only qualifier, because `in_ready` never drops. The bench drives every input at the falling edge, so that all values are settled before each rising edge. It holds reset over the first edges, so no property sees pre-reset history. Sweeps cover literal pairs across the full byte range, every address for every bit index, and both destinations. Idle cycles, and codes 6 and 7, are mixed in with random-looking operands to show that nothing moves.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int unsigned ACC_DW    = 8;
  localparam int unsigned ACC_DEPTH = 128;

  typedef enum logic [2:0] {
    OP_ADD_LIT  = 3'd0,
    OP_ADD_FILE = 3'd1,
    OP_AND_LIT  = 3'd2,
    OP_AND_FILE = 3'd3,
    OP_BIT_CLR  = 3'd4,
    OP_BIT_SET  = 3'd5,
    OP_RSV6     = 3'd6,
    OP_RSV7     = 3'd7
  } op_e;

  typedef struct packed {
    logic to_w;
    logic to_file;
    logic upd_cdc;
    logic upd_z;
  } route_t;

endpackage

// File: rtl/acc_regfile.sv
module acc_regfile #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);

  logic [DW-1:0] cells [DEPTH];

  // one register per entry, each with its own address match
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(gi));
    always_ff @(posedge clk) begin
      if (rst) begin
        cells[gi] <= '0;
      end else if (hit) begin
        cells[gi] <= wr_data;
      end
    end
  end

  assign op_data  = cells[op_addr];
  assign dbg_data = cells[dbg_addr];

endmodule

// File: rtl/acc_compute.sv
module acc_compute
  import acc_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned BW = $clog2(DW),
  localparam int unsigned NW = DW / 2
) (
  input  op_e           op,
  input  logic [DW-1:0] w_val,
  input  logic [DW-1:0] f_val,
  input  logic [DW-1:0] lit,
  input  logic [BW-1:0] bit_sel,
  output logic [DW-1:0] result,
  output logic          carry,
  output logic          dcarry,
  output logic          zero
);

  logic [DW-1:0] rhs;
  logic [DW:0]   sum_full;
  logic [NW:0]   sum_low;
  logic [DW-1:0] bit_mask;
  logic          use_lit;

  assign use_lit  = (op == OP_ADD_LIT) || (op == OP_AND_LIT);
  assign rhs      = use_lit ? lit : f_val;
  assign sum_full = {1'b0, w_val} + {1'b0, rhs};
  assign sum_low  = {1'b0, w_val[NW-1:0]} + {1'b0, rhs[NW-1:0]};
  assign bit_mask = DW'(1) << bit_sel;

  always_comb begin
    unique case (op)
      OP_ADD_LIT, OP_ADD_FILE: result = sum_full[DW-1:0];
      OP_AND_LIT, OP_AND_FILE: result = w_val & rhs;
      OP_BIT_CLR:              result = f_val & ~bit_mask;
      OP_BIT_SET:              result = f_val | bit_mask;
      default:                 result = f_val;
    endcase
  end

  assign carry  = sum_full[DW];
  assign dcarry = sum_low[NW];
  assign zero   = (result == '0);

endmodule

// File: rtl/acc_route.sv
module acc_route
  import acc_pkg::*;
(
  input  logic   valid,
  input  op_e    op,
  input  logic   dest,
  output route_t route
);

  always_comb begin
    route = '0;
    if (valid) begin
      unique case (op)
        OP_ADD_LIT: begin
          route.to_w    = 1'b1;
          route.upd_cdc = 1'b1;
          route.upd_z   = 1'b1;
        end
        OP_ADD_FILE: begin
          route.to_w    = ~dest;
          route.to_file = dest;
          route.upd_cdc = 1'b1;
          route.upd_z   = 1'b1;
        end
        OP_AND_LIT: begin
          route.to_w  = 1'b1;
          route.upd_z = 1'b1;
        end
        OP_AND_FILE: begin
          route.to_w    = ~dest;
          route.to_file = dest;
          route.upd_z   = 1'b1;
        end
        OP_BIT_CLR, OP_BIT_SET: begin
          route.to_file = 1'b1;
        end
        default: route = '0;
      endcase
    end
  end

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W     = ACC_DW,
  parameter int unsigned FILE_DEPTH = ACC_DEPTH,
  localparam int unsigned AW        = $clog2(FILE_DEPTH),
  localparam int unsigned BW        = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [AW-1:0]     in_addr,
  input  logic [DATA_W-1:0] in_lit,
  input  logic [BW-1:0]     in_bit,
  input  logic              in_dest,
  output logic [DATA_W-1:0] w_out,
  output logic              flag_c,
  output logic              flag_dc,
  output logic              flag_z,
  input  logic [AW-1:0]     dbg_addr,
  output logic [DATA_W-1:0] dbg_data
);

  op_e               op;
  route_t            rt;
  logic [DATA_W-1:0] w_q;
  logic              c_q, dc_q, z_q;
  logic [DATA_W-1:0] f_rd;
  logic [DATA_W-1:0] res;
  logic              c_n, dc_n, z_n;

  assign op       = op_e'(in_op);
  assign in_ready = 1'b1;

  acc_route u_route (
    .valid (in_valid),
    .op    (op),
    .dest  (in_dest),
    .route (rt)
  );

  acc_regfile #(.DW(DATA_W), .DEPTH(FILE_DEPTH)) u_file (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (rt.to_file),
    .wr_addr  (in_addr),
    .wr_data  (res),
    .op_addr  (in_addr),
    .op_data  (f_rd),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  acc_compute #(.DW(DATA_W)) u_alu (
    .op      (op),
    .w_val   (w_q),
    .f_val   (f_rd),
    .lit     (in_lit),
    .bit_sel (in_bit),
    .result  (res),
    .carry   (c_n),
    .dcarry  (dc_n),
    .zero    (z_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q  <= '0;
      c_q  <= 1'b0;
      dc_q <= 1'b0;
      z_q  <= 1'b0;
    end else begin
      if (rt.to_w)    w_q <= res;
      if (rt.upd_cdc) begin
        c_q  <= c_n;
        dc_q <= dc_n;
      end
      if (rt.upd_z)   z_q <= z_n;
    end
  end

  assign w_out   = w_q;
  assign flag_c  = c_q;
  assign flag_dc = dc_q;
  assign flag_z  = z_q;

endmodule

// File: rtl/acc_exec_unit_chk.sv
module acc_exec_unit_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    in_op,
  input logic [DW-1:0] in_lit,
  input logic          in_dest,
  input logic [DW-1:0] w_out,
  input logic          flag_c,
  input logic          flag_dc,
  input logic          flag_z
);

  // R2: literal add result lands in W
  a_r2_add_lit_sum: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd0) |=> (w_out == DW'($past(w_out) + $past(in_lit))));

  // R2: zero flag reflects the new W after a literal add
  a_r2_add_lit_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd0) |=> (flag_z == (w_out == '0)));

  // R3: file add with destination 1 leaves W alone
  a_r3_dest_file_keeps_w: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd1 && in_dest) |=> $stable(w_out));

  // R4, R5: AND operations keep carry and digit carry
  a_r4_and_keeps_carries: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == 3'd2 || in_op == 3'd3)) |=> ($stable(flag_c) && $stable(flag_dc)));

  // R4: literal AND result in W
  a_r4_and_lit_value: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd2) |=> (w_out == ($past(w_out) & $past(in_lit))));

  // R6, R7: bit operations touch neither W nor flags
  a_r6_bitops_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == 3'd4 || in_op == 3'd5)) |=>
      ($stable(w_out) && $stable(flag_c) && $stable(flag_dc) && $stable(flag_z)));

  // R8: idle or reserved codes hold W and flags
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || in_op[2:1] == 2'b11) |=>
      ($stable(w_out) && $stable(flag_c) && $stable(flag_dc) && $stable(flag_z)));

endmodule

bind acc_exec_unit acc_exec_unit_chk #(.DW(DATA_W)) u_chk (.*);

// File: tb/sim_acc_exec_unit.sv
module sim_acc_exec_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_op = '0;
  logic [6:0] in_addr = '0;
  logic [7:0] in_lit = '0;
  logic [2:0] in_bit = '0;
  logic       in_dest = 1'b0;
  logic [7:0] w_out;
  logic       flag_c, flag_dc, flag_z;
  logic [6:0] dbg_addr = '0;
  logic [7:0] dbg_data;

  int compared = 0;
  int mismatched = 0;

  logic [7:0] mw;
  logic       mc, mdc, mz;
  logic [7:0] mf [128];

  always #2 clk = ~clk;

  acc_exec_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_addr(in_addr), .in_lit(in_lit), .in_bit(in_bit),
    .in_dest(in_dest), .w_out(w_out), .flag_c(flag_c), .flag_dc(flag_dc),
    .flag_z(flag_z), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag, input logic [6:0] a);
    dbg_addr = a;
    #1;
    chk({tag, " W"}, w_out, mw);
    chk({tag, " C"}, {7'd0, flag_c}, {7'd0, mc});
    chk({tag, " DC"}, {7'd0, flag_dc}, {7'd0, mdc});
    chk({tag, " Z"}, {7'd0, flag_z}, {7'd0, mz});
    chk({tag, " file"}, dbg_data, mf[a]);
  endtask

  // drives one operation for one edge; v=0 gives an idle cycle
  task automatic run(input logic v, input logic [2:0] op, input logic [6:0] a,
                     input logic [7:0] k, input logic [2:0] b, input logic d,
                     input string tag);
    logic [8:0] s;
    logic [7:0] r;
    @(negedge clk);
    in_valid = v; in_op = op; in_addr = a; in_lit = k; in_bit = b; in_dest = d;
    @(negedge clk);
    in_valid = 1'b0;
    if (v) begin
      case (op)
        3'd0, 3'd1: begin
          r = (op == 3'd0) ? k : mf[a];
          s = {1'b0, mw} + {1'b0, r};
          mc = s[8];
          mdc = ({1'b0, mw[3:0]} + {1'b0, r[3:0]}) > 5'd15;
          mz = (s[7:0] == 8'd0);
          if (op == 3'd1 && d) mf[a] = s[7:0]; else mw = s[7:0];
        end
        3'd2, 3'd3: begin
          r = mw & ((op == 3'd2) ? k : mf[a]);
          mz = (r == 8'd0);
          if (op == 3'd3 && d) mf[a] = r; else mw = r;
        end
        3'd4: mf[a][b] = 1'b0;
        3'd5: mf[a][b] = 1'b1;
        default: ;
      endcase
    end
    compare_all(tag, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    mw = 0; mc = 0; mdc = 0; mz = 0;
    for (int i = 0; i < 128; i++) mf[i] = 8'd0;
    in_op = 3'd0; in_lit = 8'hFF; in_valid = 1'b1;  // driven during reset: must be ignored
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    for (int i = 0; i < 128; i++) compare_all("R1 reset", 7'(i));
    chk("R10 ready", {7'd0, in_ready}, 8'd1);

    // R2: literal add sweep with carry, digit carry and zero
    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 256; b += 13) begin
        run(1, 3'd2, 7'd0, 8'd0, 3'd0, 1'b0, "R4 clear W");
        run(1, 3'd0, 7'd0, 8'(a), 3'd0, 1'b0, "R2 load");
        run(1, 3'd0, 7'd5, 8'(b), 3'd0, 1'b1, "R2 R9 add lit");
      end
    end
    run(1, 3'd2, 7'd0, 8'd0, 3'd0, 1'b0, "R4 clear");
    run(1, 3'd0, 7'd0, 8'hF8, 3'd0, 1'b0, "R2 load F8");
    run(1, 3'd0, 7'd0, 8'h08, 3'd0, 1'b0, "R2 wrap to zero");

    // R3: fill file registers through destination 1
    for (int i = 0; i < 128; i++) begin
      run(1, 3'd2, 7'd0, 8'd0, 3'd0, 1'b0, "R4 clear");
      run(1, 3'd0, 7'd0, 8'((i * 37 + 11) & 255), 3'd0, 1'b0, "R2 set W");
      run(1, 3'd1, 7'(i), 8'd0, 3'd0, 1'b1, "R3 add to file");
    end
    // R3, R5: file ops with both destinations
    for (int i = 0; i < 128; i += 3) begin
      run(1, 3'd0, 7'd0, 8'((i * 29) & 255), 3'd0, 1'b0, "R2 vary W");
      run(1, 3'd1, 7'(i), 8'd0, 3'd0, 1'b0, "R3 add to W");
      run(1, 3'd3, 7'(i), 8'd0, 3'd0, 1'b1, "R5 and to file");
      run(1, 3'd3, 7'(i + 1), 8'd0, 3'd0, 1'b0, "R5 and to W");
      run(1, 3'd1, 7'(i + 2), 8'd0, 3'd0, 1'b1, "R3 add to file");
    end
    // R6, R7: every bit of every address
    for (int i = 0; i < 128; i++) begin
      for (int b = 0; b < 8; b++) begin
        run(1, (((i + b) % 2) == 0) ? 3'd5 : 3'd4, 7'(i), 8'd0, 3'(b), 1'b0, "R6 R7 bit op");
      end
    end
    run(1, 3'd4, 7'd9, 8'd0, 3'd7, 1'b0, "R6 clear msb");
    run(1, 3'd5, 7'd9, 8'd0, 3'd0, 1'b0, "R7 set lsb");
    // R8: idle cycles and reserved codes
    for (int i = 0; i < 16; i++) begin
      run(0, 3'(i % 6), 7'(i * 7), 8'(i * 19), 3'(i), 1'(i), "R8 idle");
      run(1, 3'd6 + 3'(i % 2), 7'(i * 5), 8'(i * 23), 3'(i), 1'(i), "R8 reserved");
    end
    for (int i = 0; i < 128; i++) compare_all("R10 debug read", 7'(i));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule